// File: doc/BRIEF.md
# Hidden-Hysteresis Comparator Combiner

This block turns three threshold comparator bits into one switching output. One bit says the signal is below a low limit, one says it is above the main threshold, and one says it is above a high limit. The output moves only when the main threshold is crossed, so no hysteresis shows in when it switches. The two outer limits never drive the output. They only decide whether the next crossing of the main threshold is allowed through.

After the output goes high it is locked high. Only a sighting of the high limit re-arms it, and then a fall of the main bit may drive it low. Going low works the same way with the low limit. The output path is combinational gating of the raw main bit, so a permitted crossing reaches the output with no clock delay. The lock state sits in flip-flops that see the comparator bits through a synchronizer of `SYNC_STAGES` flops. Noise around the main threshold that follows a committed transition therefore cannot re-switch the output.

Top module: `hidden_hyst_combiner`

## Requirements
- R1: After reset the committed level is low and the rising transition is armed, so with the main bit low the output is low.
- R2: While armed, the output equals the main comparator bit combinationally, with no clock edge between a main change and the output change.
- R3: A main-bit value different from the committed level commits once it has been held for SYNC_STAGES+1 rising clock edges. The output is then locked at that level, and later main-bit changes leave it unchanged.
- R4: While locked high, the low-limit bit has no effect: a main fall after it leaves the output high.
- R5: While locked high, the high-limit bit held for SYNC_STAGES+1 edges arms the fall, after which a main fall drives the output low at once.
- R6: While locked low, the high-limit bit has no effect: a main rise after it leaves the output low.
- R7: While locked low, the low-limit bit held for SYNC_STAGES+1 edges arms the rise, after which a main rise drives the output high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the lock state |
| rst_n | input | 1 | Synchronous active-low reset |
| lo_lim_i | input | 1 | High when the signal is below the low hysteresis limit |
| mid_i | input | 1 | High when the signal is above the main threshold |
| hi_lim_i | input | 1 | High when the signal is above the high hysteresis limit |
| sw_o | output | 1 | Combined switching output |

## Verification
The bench builds the block with SYNC_STAGES set to 2, so each commit and each arming takes three rising edges. This lets the directed tasks hold a stimulus just long enough and then probe one cycle past that point. The three comparator bits come from a modelled signal level compared against a low limit, zero and a high limit. This lets every combination of lock state and limit sighting be reached, including limit sightings of the wrong polarity, each probed right after a main-threshold crossing.

// File: rtl/hhc_pkg.sv
// Package: shared constants and bit positions for the hidden-hysteresis combiner.
// Assumes: the comparator inputs are packed low limit, main, high limit.
package hhc_pkg;
    localparam int CMP_W   = 3;
    localparam int IDX_LO  = 0;
    localparam int IDX_MID = 1;
    localparam int IDX_HI  = 2;
    localparam int DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/hhc_sync_bank.sv
// Module: bank of independent flop chains that bring asynchronous bits into clk.
// Assumes: STAGES >= 1; each bit is synchronized on its own, no coherency between bits.
module hhc_sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            // Shift the raw bit through STAGES flops, clearing on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else if (STAGES == 1) chain_q <= async_i[b];
                else chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
            assign sync_o[b] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hhc_lock_ctrl.sv
// Module: holds the committed level and the arm flag of the combiner.
// Assumes: inputs are already synchronized to clk.
// While armed, a main value that differs from the committed level commits and locks.
// While locked, only the limit on the committed side re-arms.
module hhc_lock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_s,
    input  logic mid_s,
    input  logic hi_s,
    output logic lvl_q,
    output logic armed_q
);
    logic rearm;

    // Re-arm condition: the limit beyond the committed level has been seen.
    always_comb begin
        rearm = lvl_q ? hi_s : lo_s;
    end

    // Commit on an armed crossing, re-arm on the matching limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            if (mid_s != lvl_q) begin
                lvl_q   <= mid_s;
                armed_q <= 1'b0;
            end
        end else if (rearm) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/hhc_out_gate.sv
// Module: combinational output gate; passes the raw main bit when armed,
// otherwise holds the committed level. No clocked element on this path.
module hhc_out_gate (
    input  logic mid_raw,
    input  logic lvl_q,
    input  logic armed_q,
    output logic sw_o
);
    // Select between the live main bit and the locked level.
    always_comb begin
        sw_o = armed_q ? mid_raw : lvl_q;
    end
endmodule

// File: rtl/hidden_hyst_combiner.sv
// Module: top of the hidden-hysteresis comparator combiner.
// Assumes: comparator bits are asynchronous to clk; a crossing that must commit
// is held for at least SYNC_STAGES+1 clock edges.
module hidden_hyst_combiner #(
    parameter int SYNC_STAGES = hhc_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_lim_i,
    input  logic mid_i,
    input  logic hi_lim_i,
    output logic sw_o
);
    import hhc_pkg::*;

    logic [CMP_W-1:0] raw_bits;
    logic [CMP_W-1:0] sync_bits;
    logic lo_s, mid_s, hi_s;
    logic lvl_q, armed_q;

    assign raw_bits[IDX_LO]  = lo_lim_i;
    assign raw_bits[IDX_MID] = mid_i;
    assign raw_bits[IDX_HI]  = hi_lim_i;

    hhc_sync_bank #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bits),
        .sync_o  (sync_bits)
    );

    assign lo_s  = sync_bits[IDX_LO];
    assign mid_s = sync_bits[IDX_MID];
    assign hi_s  = sync_bits[IDX_HI];

    hhc_lock_ctrl u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_s    (lo_s),
        .mid_s   (mid_s),
        .hi_s    (hi_s),
        .lvl_q   (lvl_q),
        .armed_q (armed_q)
    );

    hhc_out_gate u_gate (
        .mid_raw (mid_i),
        .lvl_q   (lvl_q),
        .armed_q (armed_q),
        .sw_o    (sw_o)
    );
endmodule

// File: rtl/hhc_checker.sv
// Module: assertion checker bound to the combiner top.
module hhc_checker (
    input logic clk,
    input logic rst_n,
    input logic mid_i,
    input logic sw_o,
    input logic lo_s,
    input logic hi_s,
    input logic lvl_q,
    input logic armed_q
);
    AST_ARMED_FOLLOWS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (sw_o == mid_i)); // R2

    AST_COMMIT_CHANGES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed_q) |-> (lvl_q != $past(lvl_q))); // R3

    AST_LOCKED_OUTPUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && $past(!armed_q)) |-> $stable(sw_o)); // R3

    AST_REARM_HIGH_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(armed_q) && $past(lvl_q)) |-> $past(hi_s)); // R5

    AST_REARM_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(armed_q) && !$past(lvl_q)) |-> $past(lo_s)); // R7
endmodule

bind hidden_hyst_combiner hhc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mid_i   (mid_i),
    .sw_o    (sw_o),
    .lo_s    (lo_s),
    .hi_s    (hi_s),
    .lvl_q   (lvl_q),
    .armed_q (armed_q)
);

// File: tb/hidden_hyst_combiner_test.sv
module hidden_hyst_combiner_test;
    localparam int STG = 2;
    localparam int HOLD = STG + 2;   // negedges to wait so a commit or arming has landed
    localparam int LIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lo_lim_i, mid_i, hi_lim_i;
    logic sw_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hidden_hyst_combiner #(.SYNC_STAGES(STG)) uut (
        .clk(clk), .rst_n(rst_n), .lo_lim_i(lo_lim_i),
        .mid_i(mid_i), .hi_lim_i(hi_lim_i), .sw_o(sw_o)
    );

    // Modelled signal level compared against -LIM, 0 and +LIM.
    task automatic set_level(input int lv);
        lo_lim_i = (lv < -LIM);
        mid_i    = (lv > 0);
        hi_lim_i = (lv > LIM);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        #1;
        checks++;
        if (sw_o !== exp) begin
            failures++;
            $display("FAIL %s: sw_o=%b expected=%b", req, sw_o, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        set_level(-5);
        rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", 1'b0);
        settle(HOLD);
        check("R1", 1'b0);
    endtask

    task automatic t_armed_follow();
        do_reset();
        set_level(5);
        check("R2", 1'b1);        // no clock edge in between
        set_level(-5);
        check("R2", 1'b0);        // short excursion still visible while armed
        settle(HOLD);
        check("R2", 1'b0);
    endtask

    task automatic t_lock_high();
        do_reset();
        set_level(5);
        settle(HOLD);
        set_level(-5);
        check("R3", 1'b1);
        settle(HOLD);
        check("R3", 1'b1);
        set_level(-50);           // low limit while locked high
        settle(HOLD);
        set_level(-5);
        check("R4", 1'b1);
        set_level(50);            // high limit arms the fall
        settle(HOLD);
        set_level(5);
        settle(1);
        check("R5", 1'b1);
        set_level(-5);
        check("R5", 1'b0);
    endtask

    task automatic t_lock_low();
        do_reset();
        set_level(5);
        settle(HOLD);
        set_level(50);
        settle(HOLD);
        set_level(-5);
        settle(HOLD);             // committed low, locked
        set_level(5);
        check("R3", 1'b0);
        set_level(50);            // high limit while locked low
        settle(HOLD);
        set_level(5);
        check("R6", 1'b0);
        set_level(-50);           // low limit arms the rise
        settle(HOLD);
        set_level(-5);
        settle(1);
        check("R7", 1'b0);
        set_level(5);
        check("R7", 1'b1);
    endtask

    task automatic t_reset_from_lock();
        do_reset();
        set_level(5);
        settle(HOLD);             // locked high
        do_reset();
        check("R1", 1'b0);
        set_level(5);
        check("R1", 1'b1);        // rise armed out of reset
    endtask

    initial begin
        set_level(-5);
        t_reset();
        t_armed_follow();
        t_lock_high();
        t_lock_low();
        t_reset_from_lock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule